// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit logical address into a 24-bit physical address, which reaches a 16 MB physical space. The logical space is cut into sixteen 4 KB pages. The top four logical bits pick one of sixteen frame registers. The 12-bit frame number held there replaces those four bits. The low twelve bits pass through unchanged as the offset within the page.

After reset the unit is in bypass. The logical address appears unchanged on the physical side with the upper eight bits at zero, so boot code runs from physical address zero. Software loads the frame registers through a small write port and then sets the enable bit. From then on, any 4 KB page can be placed anywhere in physical memory, for example to put DRAM under the lowest 256 KB.

The translated address is registered: a logical address presented at one rising edge appears on `phys_addr` after that edge.

Top module: `page_xlate_unit`

## Requirements
- R1: While `rst_n` is low, and after the first edge following reset, `phys_addr` is zero and translation is disabled.
- R2: With translation disabled, `phys_addr` equals the logical address sampled at the previous edge, zero-extended to 24 bits.
- R3: With translation enabled, `phys_addr[23:12]` equals the frame register selected by bits [15:12] of the logical address sampled at the previous edge. `phys_addr[11:0]` equals bits [11:0] of that address.
- R4: Reset loads frame register n with the value n. Enabling translation with no table writes therefore gives the same result as bypass.
- R5: A write with `cfg_addr[4]`=0 and `cfg_we`=1 stores `cfg_data[11:0]` into frame register `cfg_addr[3:0]`. The new value is used by every lookup sampled at a later edge.
- R6: A lookup sampled at the same edge as a write to its frame register returns the value from before the write.
- R7: A write with `cfg_addr[4]`=1 sets the enable bit to `cfg_data[0]`. The enable bit is not used until the edge after the write, so the lookup sampled at that same edge still uses the old mode.
- R8: Table writes made while in bypass do not change `phys_addr`, but are kept and take effect once translation is enabled.
- R9: A write to the enable bit leaves the frame registers unchanged, and a write to a frame register leaves the enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 5 | Bit 4 selects the enable bit (1) or the frame table (0); bits 3:0 select the frame register |
| cfg_data | input | 12 | Write data: a frame number, or the enable value in bit 0 |
| log_addr | input | 16 | Logical address to translate |
| phys_addr | output | 24 | Registered physical address |

## Verification
The hardest case to reach from the ports is a frame-register write and a lookup of that same page landing on one edge, while translation is active. That case must return the old frame, and the next lookup must return the new one. The bench drives this case directly. It issues writes whose index matches the page of the logical address it presents in the same cycle. It does this for every page, once with a fresh frame pattern and once again with a second pattern. A bench model computes the result arithmetically from the register state as it stood before the edge. Mode switches get the same treatment: the enable bit is set and cleared in the same cycle as a lookup.

// File: rtl/ptu_pkg.sv
// Shared sizing constants for the paged address translation unit.
// Assumes the page count never exceeds the frame number range, so an
// identity reset value always fits in a frame register.
package ptu_pkg;
    localparam int LA_W   = 16;
    localparam int PA_W   = 24;
    localparam int OFS_W  = 12;
    localparam int IDX_W  = LA_W - OFS_W;
    localparam int FRM_W  = PA_W - OFS_W;
    localparam int NPAGE  = 1 << IDX_W;
    localparam int CFG_AW = IDX_W + 1;
endpackage

// File: rtl/ptu_frame_table.sv
// Frame register file: one frame number per logical page.
// Assumes a single write port and a combinational read port. A write
// lands at the clock edge, so a same-edge read sees the old value.
// Reset loads entry n with n (identity mapping).
module ptu_frame_table #(
    parameter int IDX_W = 4,
    parameter int FRM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [FRM_W-1:0] wr_frame,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [FRM_W-1:0] rd_frame
);
    localparam int NENT = 1 << IDX_W;

    logic [FRM_W-1:0] frame_q [NENT];

    for (genvar n = 0; n < NENT; n++) begin : g_ent
        // Holds one frame number, identity on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                frame_q[n] <= FRM_W'(n);
            else if (wr_en && (wr_idx == IDX_W'(n)))
                frame_q[n] <= wr_frame;
        end
    end

    // Selects the frame for the page being looked up.
    always_comb rd_frame = frame_q[rd_idx];
endmodule

// File: rtl/ptu_ctrl_reg.sv
// Translation enable flag. Clear on reset. A write takes effect at the
// edge, so the new value governs lookups from the following edge on.
module ptu_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    output logic en_q
);
    // Stores the enable bit written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en)
            en_q <= wr_val;
    end
endmodule

// File: rtl/ptu_addr_compose.sv
// Builds the physical address and registers it. In bypass the logical
// address is zero-extended. When enabled, the frame replaces the page
// bits. Assumes PA_W = FRM_W + OFS_W and LA_W > OFS_W.
module ptu_addr_compose #(
    parameter int LA_W  = 16,
    parameter int OFS_W = 12,
    parameter int FRM_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xlate_en,
    input  logic [LA_W-1:0]        log_addr,
    input  logic [FRM_W-1:0]       frame,
    output logic [FRM_W+OFS_W-1:0] phys_q
);
    localparam int PA_W = FRM_W + OFS_W;

    logic [PA_W-1:0] phys_d;

    // Chooses between the translated and the pass-through address.
    always_comb begin
        if (xlate_en)
            phys_d = {frame, log_addr[OFS_W-1:0]};
        else
            phys_d = PA_W'(log_addr);
    end

    // Registers the physical address; zero during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phys_q <= '0;
        else
            phys_q <= phys_d;
    end
endmodule

// File: rtl/page_xlate_unit.sv
// Top of the paged address translation unit. It decodes the
// configuration port into a frame-table write or an enable write, looks
// up the frame for the incoming page, and registers the physical address.
// Assumes: synchronous active-low reset; one configuration write per cycle.
module page_xlate_unit
    import ptu_pkg::*;
#(
    parameter int LA_W_P  = LA_W,
    parameter int OFS_W_P = OFS_W,
    parameter int PA_W_P  = PA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [LA_W_P-OFS_W_P:0] cfg_addr,
    input  logic [PA_W_P-OFS_W_P-1:0] cfg_data,
    input  logic [LA_W_P-1:0]      log_addr,
    output logic [PA_W_P-1:0]      phys_addr
);
    localparam int IW = LA_W_P - OFS_W_P;
    localparam int FW = PA_W_P - OFS_W_P;

    logic          tbl_we;
    logic          ctl_we;
    logic          xlate_en;
    logic [FW-1:0] cur_frame;

    // Splits configuration writes between the table and the enable bit.
    always_comb begin
        tbl_we = cfg_we && !cfg_addr[IW];
        ctl_we = cfg_we &&  cfg_addr[IW];
    end

    ptu_frame_table #(.IDX_W(IW), .FRM_W(FW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (cfg_addr[IW-1:0]),
        .wr_frame (cfg_data),
        .rd_idx   (log_addr[LA_W_P-1:OFS_W_P]),
        .rd_frame (cur_frame)
    );

    ptu_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctl_we),
        .wr_val (cfg_data[0]),
        .en_q   (xlate_en)
    );

    ptu_addr_compose #(.LA_W(LA_W_P), .OFS_W(OFS_W_P), .FRM_W(FW)) u_compose (
        .clk      (clk),
        .rst_n    (rst_n),
        .xlate_en (xlate_en),
        .log_addr (log_addr),
        .frame    (cur_frame),
        .phys_q   (phys_addr)
    );
endmodule

// File: rtl/page_xlate_unit_chk.sv
// Property checker for page_xlate_unit, bound to every instance of it.
// Observes the ports and the enable flag.
module page_xlate_unit_chk
    import ptu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [FRM_W-1:0]  cfg_data,
    input logic [LA_W-1:0]   log_addr,
    input logic [PA_W-1:0]   phys_addr,
    input logic              xlate_en
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (phys_addr == '0 && !xlate_en));

    // R2
    bypass_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_en |=> phys_addr == PA_W'($past(log_addr)));

    // R3
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phys_addr[OFS_W-1:0] == $past(log_addr[OFS_W-1:0]));

    // R7
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr[IDX_W]) |=> xlate_en == $past(cfg_data[0]));

    // R9
    table_write_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr[IDX_W]) |=> $stable(xlate_en));
endmodule

bind page_xlate_unit page_xlate_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_data  (cfg_data),
    .log_addr  (log_addr),
    .phys_addr (phys_addr),
    .xlate_en  (xlate_en)
);

// File: tb/page_xlate_unit_tb_top.sv
// Self-checking bench: near-exhaustive address sweeps in both modes,
// with expected values worked out arithmetically from a small model.
module page_xlate_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [11:0] cfg_data = '0;
    logic [15:0] log_addr = '0;
    logic [23:0] phys_addr;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    int mdl_tbl [16];
    bit mdl_en;

    page_xlate_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .log_addr  (log_addr),
        .phys_addr (phys_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int exp, input string tag);
        vectors++;
        if (int'(phys_addr) != exp) begin
            fails++;
            $display("FAIL %s: phys_addr=%06h expected=%06h", tag, phys_addr, exp);
        end
    endtask

    // Called at a negedge: drive, let one edge pass, check at the next negedge.
    task automatic step(input bit we, input int a, input int d, input int la, input string tag);
        int exp;
        exp = mdl_en ? ((mdl_tbl[(la >> 12) & 15] << 12) | (la & 'hfff)) : (la & 'hffff);
        cfg_we   = we;
        cfg_addr = 5'(a);
        cfg_data = 12'(d);
        log_addr = 16'(la);
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
        if (we) begin
            if (a & 16) mdl_en = d[0];
            else        mdl_tbl[a & 15] = d & 'hfff;
        end
        cfg_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl_tbl[i] = i;
        mdl_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(0, "R1");
        rst_n = 1'b1;

        // R1/R2: bypass sweep of the logical space.
        for (int la = 0; la < 65536; la += 7) step(0, 0, 0, la, "R2");
        step(0, 0, 0, 'hffff, "R2");

        // R7: enable with a same-edge lookup (old mode), then R4 identity sweep.
        step(1, 16, 1, 'h7abc, "R7");
        for (int la = 3; la < 65536; la += 13) step(0, 0, 0, la, "R4");

        // R5/R6: rewrite every frame while looking up the same page.
        for (int p = 0; p < 16; p++) begin
            step(1, p, (p * 37 + 5) & 'hfff, (p << 12) | (p * 111), "R6");
            step(0, 0, 0, (p << 12) | 'hfff, "R5");
        end
        for (int la = 1; la < 65536; la += 11) step(0, 0, 0, la, "R3");

        // R9: enable writes keep the table; R7 clear returns to bypass.
        step(1, 16, 1, 'h2345, "R9");
        step(0, 0, 0, 'h2345, "R9");
        step(1, 16, 0, 'h9876, "R7");
        step(0, 0, 0, 'h9876, "R7");

        // R8: table writes in bypass are invisible until enable.
        for (int p = 0; p < 16; p++)
            step(1, p, 'hfff - p * 200, (p << 12) | 'h0a5, "R8");
        step(1, 16, 1, 'hc001, "R8");
        for (int p = 0; p < 16; p++) step(0, 0, 0, (p << 12) | (p * 257 & 'hfff), "R8");

        // R6 again with a second pattern, R1 on a re-reset.
        for (int p = 0; p < 16; p++)
            step(1, p, p * 4093 & 'hfff, (p << 12) | 'h800, "R6");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(0, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mdl_tbl[i] = i;
        mdl_en = 0;
        step(1, 16, 1, 'h4321, "R1");
        step(0, 0, 0, 'hb0b0, "R4");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected=<%0d", MAX_CYC, MAX_CYC);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule